// File: doc/BRIEF.md
# Serial Transmitter with Idle Preamble and Break

This block is the sending half of an asynchronous serial port. Software writes a character into a holding register with a single-cycle write strobe. When the transmitter is enabled, the character moves into a separate frame shift register on a bit-clock boundary and is sent one bit at a time. The serial line idles high. A frame is one low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit.

Two status flags tell software what is going on. The holding-empty flag sets when a character leaves the holding register. The line-done flag sets when a frame ends and nothing else is queued behind it. Each flag has its own clear strobe, and each can raise the interrupt request through its own enable. A 5-bit rate code sets the bit time.

Two kinds of frame come from control inputs rather than from data. When the enable rises, one all-ones idle frame is sent before anything else. While the break request is held, all-zeros frames of full length are sent, and a single high mark bit follows once the request drops. If the enable is cleared during a frame, that frame still finishes before the line goes back to idle.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd`=1, `dreg_empty`=1, `tx_done`=1, and `irq`=0 while both interrupt enables are 0.
- R2: A data frame is a start bit of 0, then the data bits LSB first, then a stop bit of 1. There are 8 data bits (`wr_data[7:0]`) when `long_word`=0 and 9 data bits (`wr_data[8:0]`) when `long_word`=1.
- R3: Every bit lasts P clock cycles. P = S × 2^`baud_code[2:0]`, where S is set by `baud_code[4:3]` as follows: 00→1, 01→3, 10→4, 11→13.
- R4: A written character moves to the shift register only on a bit-clock tick and only while `tx_en`=1. A character written while the transmitter is disabled stays held: `dreg_empty` remains 0 and the line stays high. The move sets `dreg_empty`.
- R5: `tx_done` sets when a frame ends and no further frame starts on that tick. Two characters sent back to back do not set it between them.
- R6: A 0→1 change of `tx_en` sends one idle frame of all ones, as long as a data frame for the current `long_word`, before any queued character.
- R7: While `brk_req`=1 and `tx_en`=1, back-to-back all-zeros frames of data-frame length are sent. When the request drops, one high bit of one bit time is sent before the next frame. A break takes priority over queued data.
- R8: Clearing `tx_en` during a frame lets that frame finish intact. After the frame the line stays high, and `tx_done` sets even if a character is still held.
- R9: `irq` = (`tie` AND `dreg_empty`) OR (`tcie` AND `tx_done`).
- R10: `clr_empty` clears `dreg_empty`, and `clr_done` clears `tx_done`. A set event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| long_word | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| brk_req | input | 1 | Request break frames |
| tie | input | 1 | Interrupt enable for holding-empty |
| tcie | input | 1 | Interrupt enable for line-done |
| baud_code | input | 5 | Bit-rate select code |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| clr_empty | input | 1 | Clears `dreg_empty` |
| clr_done | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial output line |
| dreg_empty | output | 1 | Holding register has been moved out |
| tx_done | output | 1 | Line finished with nothing queued |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every control input changes only between clock edges, and that `wr_stb`, `clr_empty` and `clr_done` are single-cycle pulses. They also assume that `baud_code` is not changed in the middle of a frame whose bit timing is being checked. The bench drives every input on the falling edge. It changes the rate code only while the line is idle, and then waits one full old bit time so that the free-running divider has reloaded before the next character. Break and disable requests are timed against known tick phases, so the expected run lengths of low and high bits can be computed exactly.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int LONG_W  = 9;
  localparam int FRAME_W = LONG_W + 2;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_BRK,
    SRC_MARK,
    SRC_PRE,
    SRC_DATA
  } src_e;

  // Prescaler factor picked by the upper two code bits.
  function automatic int unsigned prescale_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 3;
      2'd2:    return 4;
      default: return 13;
    endcase
  endfunction

  // Clock cycles per serial bit.
  function automatic int unsigned bit_period(input logic [4:0] code);
    return prescale_of(code[4:3]) << code[2:0];
  endfunction

  // Number of bit times in a full frame: start + data + stop.
  function automatic logic [LEN_W-1:0] frame_bits(input logic long_mode);
    return long_mode ? LEN_W'(LONG_W + 2) : LEN_W'(LONG_W + 1);
  endfunction

  // Frame image, bit 0 sent first.
  function automatic logic [FRAME_W-1:0] pack_data(input logic [LONG_W-1:0] d,
                                                   input logic long_mode);
    if (long_mode) return {1'b1, d, 1'b0};
    else           return {2'b11, d[LONG_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/sertx_baudgen.sv
module sertx_baudgen #(
  parameter int CNT_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] code,
  output logic       tick
);
  import sertx_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  always_comb reload = CNT_W'(bit_period(code) - 1);

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= reload;
    else           cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int FRAME_W = 11,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic [LEN_W-1:0]   load_len,
  output logic               busy,
  output logic               last,
  output logic               line
);
  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   left;

  assign last = busy && (left == LEN_W'(1));
  assign line = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (tick) begin
      if (load) begin
        sh   <= load_word;
        left <= load_len;
        busy <= 1'b1;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int CNT_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       long_word,
  input  logic       brk_req,
  input  logic       tie,
  input  logic       tcie,
  input  logic [4:0] baud_code,
  input  logic       wr_stb,
  input  logic [8:0] wr_data,
  input  logic       clr_empty,
  input  logic       clr_done,
  output logic       txd,
  output logic       dreg_empty,
  output logic       tx_done,
  output logic       irq
);
  import sertx_pkg::*;

  logic tick;
  logic busy;
  logic last;
  logic load;
  logic [FRAME_W-1:0] load_word;
  logic [LEN_W-1:0]   load_len;
  src_e src;

  logic [LONG_W-1:0] hold_q;
  logic full_q;
  logic en_q;
  logic pre_pend;
  logic mark_pend;
  logic en_rise;
  logic slot;

  // Named events for the checker.
  logic ev_xfer;
  logic ev_brk;
  logic ev_end;

  sertx_baudgen #(.CNT_W(CNT_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .code (baud_code),
    .tick (tick)
  );

  sertx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .load_word(load_word),
    .load_len (load_len),
    .busy     (busy),
    .last     (last),
    .line     (txd)
  );

  assign en_rise = tx_en && !en_q;
  assign slot    = tick && (!busy || last);

  // Frame source priority: break, trailing mark, preamble, data.
  always_comb begin
    src = SRC_NONE;
    if (slot) begin
      if (tx_en && brk_req)                src = SRC_BRK;
      else if (mark_pend)                  src = SRC_MARK;
      else if (tx_en && (pre_pend || en_rise)) src = SRC_PRE;
      else if (tx_en && full_q)            src = SRC_DATA;
    end
  end

  always_comb begin
    load_word = '1;
    load_len  = frame_bits(long_word);
    case (src)
      SRC_BRK:  load_word = '0;
      SRC_MARK: load_len  = LEN_W'(1);
      SRC_DATA: load_word = pack_data(hold_q, long_word);
      default:  load_word = '1;
    endcase
  end

  assign load    = (src != SRC_NONE);
  assign ev_xfer = (src == SRC_DATA);
  assign ev_brk  = (src == SRC_BRK);
  assign ev_end  = tick && last && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      full_q     <= 1'b0;
      en_q       <= 1'b0;
      pre_pend   <= 1'b0;
      mark_pend  <= 1'b0;
      dreg_empty <= 1'b1;
      tx_done    <= 1'b1;
    end else begin
      en_q <= tx_en;

      if (!tx_en)              pre_pend <= 1'b0;
      else if (src == SRC_PRE) pre_pend <= 1'b0;
      else if (en_rise)        pre_pend <= 1'b1;

      if (ev_xfer)               mark_pend <= mark_pend;
      if (src == SRC_BRK)        mark_pend <= 1'b1;
      else if (src == SRC_MARK)  mark_pend <= 1'b0;

      if (wr_stb)       hold_q <= wr_data;
      if (wr_stb)       full_q <= 1'b1;
      else if (ev_xfer) full_q <= 1'b0;

      if (ev_xfer)        dreg_empty <= 1'b1;
      else if (clr_empty) dreg_empty <= 1'b0;

      if (ev_end)         tx_done <= 1'b1;
      else if (clr_done)  tx_done <= 1'b0;
    end
  end

  assign irq = (tie && dreg_empty) || (tcie && tx_done);

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic busy,
  input logic ev_xfer,
  input logic ev_brk,
  input logic ev_end,
  input logic tx_en,
  input logic brk_req,
  input logic txd,
  input logic dreg_empty,
  input logic tx_done
);
  // R4: moves only on a tick and only when enabled
  a_r4_xfer_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |-> (tick && tx_en));

  // R4: the move leaves the holding-empty flag set
  a_r4_xfer_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |=> dreg_empty);

  // R2: a data frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |=> !txd);

  // R5: a frame end with nothing behind it leaves the line free and done set
  a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (tx_done && !busy));

  // R7: break frames only on request
  a_r7_break_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk |-> brk_req);

  // R8: no frame in flight means a high line
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
endmodule

bind sertx_core sertx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .busy      (busy),
  .ev_xfer   (ev_xfer),
  .ev_brk    (ev_brk),
  .ev_end    (ev_end),
  .tx_en     (tx_en),
  .brk_req   (brk_req),
  .txd       (txd),
  .dreg_empty(dreg_empty),
  .tx_done   (tx_done)
);

// File: tb/sim_sertx_core.sv
`timescale 1ns/1ps
module sim_sertx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, long_word = 1'b0, brk_req = 1'b0;
  logic       tie = 1'b0, tcie = 1'b0;
  logic [4:0] baud_code = 5'd0;
  logic       wr_stb = 1'b0, clr_empty = 1'b0, clr_done = 1'b0;
  logic [8:0] wr_data = '0;
  logic       txd, dreg_empty, tx_done, irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sertx_core u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .long_word(long_word),
    .brk_req(brk_req), .tie(tie), .tcie(tcie), .baud_code(baud_code),
    .wr_stb(wr_stb), .wr_data(wr_data), .clr_empty(clr_empty),
    .clr_done(clr_done), .txd(txd), .dreg_empty(dreg_empty),
    .tx_done(tx_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench view of the bit time: factor table times a power of two.
  function automatic int per_of(input logic [4:0] c);
    int f;
    f = (c[4:3] == 2'b00) ? 1 : (c[4:3] == 2'b01) ? 3 : (c[4:3] == 2'b10) ? 4 : 13;
    return f * (2 ** int'(c[2:0]));
  endfunction

  task automatic put(input logic [8:0] d);
    wr_stb = 1'b1; wr_data = d; clr_empty = 1'b1; clr_done = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; clr_empty = 1'b0; clr_done = 1'b0;
  endtask

  task automatic wait_fall();
    while (1) begin
      @(negedge clk);
      if (txd == 1'b0) break;
    end
  endtask

  // Current negedge is the first cycle of bit 0; samples the middle of each bit.
  task automatic read_bits(input int n, input int p, output logic [10:0] v);
    int pos = 0;
    v = '1;
    for (int k = 0; k < n; k++) begin
      int tgt = k * p + (p - 1) / 2;
      step(tgt - pos);
      pos = tgt;
      v[k] = txd;
    end
  endtask

  task automatic set_code(input logic [4:0] c);
    int old = per_of(baud_code);
    baud_code = c;
    step(old + 2);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [10:0] v;
    int n, l, h, p;
    logic [8:0] d;

    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(dreg_empty == 1'b1, "R1 empty", dreg_empty, 1);
    chk(tx_done == 1'b1, "R1 done", tx_done, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R9 / R10 flag and interrupt logic while idle
    tie = 1'b1; step(1);
    chk(irq == 1'b1, "R9 tie irq", irq, 1);
    clr_empty = 1'b1; step(1); clr_empty = 1'b0; step(1);
    chk(dreg_empty == 1'b0, "R10 clr_empty", dreg_empty, 0);
    chk(irq == 1'b0, "R9 irq after clear", irq, 0);
    tcie = 1'b1; step(1);
    chk(irq == 1'b1, "R9 tcie irq", irq, 1);
    clr_done = 1'b1; step(1); clr_done = 1'b0; step(1);
    chk(tx_done == 1'b0, "R10 clr_done", tx_done, 0);
    chk(irq == 1'b0, "R9 irq both clear", irq, 0);
    tie = 1'b0; tcie = 1'b0;

    // R4 character held while disabled
    put(9'h05A);
    step(30);
    chk(dreg_empty == 1'b0, "R4 held empty", dreg_empty, 0);
    chk(txd == 1'b1, "R4 held line", txd, 1);

    // R6 preamble on enable rise, P=1
    tx_en = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 5) chk(dreg_empty == 1'b0, "R6 empty during preamble", dreg_empty, 0);
      if (txd == 1'b0 || n > 100) break;
    end
    chk(n == 11, "R6 preamble length", n, 11);
    read_bits(10, 1, v);
    chk(v[0] == 1'b0, "R2 start", v[0], 0);
    chk(v[8:1] == 8'h5A, "R2 data after preamble", v[8:1], 8'h5A);
    chk(v[9] == 1'b1, "R2 stop", v[9], 1);
    chk(dreg_empty == 1'b1, "R4 empty set", dreg_empty, 1);
    step(2);
    chk(tx_done == 1'b1, "R5 done after frame", tx_done, 1);

    // R2 nine-bit sweep, P=1
    long_word = 1'b1;
    for (int i = 0; i < 12; i++) begin
      d = (i == 0) ? 9'h1FF : (i == 1) ? 9'h100 : 9'((i * 83 + 7) % 512);
      put(d);
      wait_fall();
      read_bits(11, 1, v);
      chk(v[9:1] == d, "R2 nine-bit data", v[9:1], d);
      chk(v[10] == 1'b1, "R2 nine-bit stop", v[10], 1);
      step(2);
      chk(tx_done == 1'b1, "R5 nine-bit done", tx_done, 1);
    end
    long_word = 1'b0;

    // R3 every rate code
    for (int c = 0; c < 32; c++) begin
      set_code(5'(c));
      p = per_of(5'(c));
      d = {1'b0, 5'(c), 3'b101};
      put(d);
      wait_fall();
      l = 0;
      while (txd == 1'b0 && l < 5000) begin
        l++;
        @(negedge clk);
      end
      chk(l == p, "R3 bit period", l, p);
      read_bits(9, p, v);
      chk(v[7:0] == d[7:0], "R2 data at rate", v[7:0], d[7:0]);
      chk(v[8] == 1'b1, "R2 stop at rate", v[8], 1);
      step(p);
      chk(tx_done == 1'b1, "R5 done at rate", tx_done, 1);
    end

    // R5 back to back, P=4
    set_code(5'b10000);
    put(9'h03C);
    while (dreg_empty == 1'b0) @(negedge clk);
    put(9'h0C3);
    wait_fall();
    read_bits(10, 4, v);
    chk(v[8:1] == 8'h3C, "R5 first char", v[8:1], 8'h3C);
    wait_fall();
    chk(tx_done == 1'b0, "R5 no done between", tx_done, 0);
    read_bits(10, 4, v);
    chk(v[8:1] == 8'hC3, "R5 second char", v[8:1], 8'hC3);
    step(4);
    chk(tx_done == 1'b1, "R5 done after pair", tx_done, 1);

    // R8 disable in mid-frame, P=4
    put(9'h096);
    wait_fall();
    fork
      read_bits(10, 4, v);
      begin
        step(10);
        tx_en = 1'b0;
        put(9'h011);
      end
    join
    chk(v[0] == 1'b0 && v[9] == 1'b1, "R8 frame framing", {v[9], v[0]}, 2);
    chk(v[8:1] == 8'h96, "R8 frame finished", v[8:1], 8'h96);
    step(4);
    chk(tx_done == 1'b1, "R8 done when disabled", tx_done, 1);
    chk(dreg_empty == 1'b0, "R4 held after disable", dreg_empty, 0);
    h = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (txd == 1'b1) h++;
    end
    chk(h == 100, "R8 line high after", h, 100);
    tx_en = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (txd == 1'b0 || n > 200) break;
    end
    chk(n >= 41 && n <= 44, "R6 preamble at P=4", n, 41);
    read_bits(10, 4, v);
    chk(v[8:1] == 8'h11, "R4 held char sent", v[8:1], 8'h11);
    step(4);

    // R7 break with data queued, P=2
    set_code(5'b00001);
    brk_req = 1'b1;
    fork
      begin
        step(25);
        brk_req = 1'b0;
      end
      begin
        step(3);
        put(9'h04E);
      end
      begin
        wait_fall();
        l = 0;
        while (txd == 1'b0 && l < 500) begin
          l++;
          @(negedge clk);
        end
        h = 0;
        while (txd == 1'b1 && h < 500) begin
          h++;
          @(negedge clk);
        end
      end
    join
    chk(l == 40, "R7 break low run", l, 40);
    chk(h == 2, "R7 mark after break", h, 2);
    read_bits(10, 2, v);
    chk(v[8:1] == 8'h4E, "R7 data after break", v[8:1], 8'h4E);
    step(2);
    chk(tx_done == 1'b1, "R5 done after break data", tx_done, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule